// File: doc/BRIEF.md
# Two-Part Interframe Deferral Timer

This block is the deference process of a half-duplex CSMA/CD Ethernet MAC. It counts idle bit times between frames and tells the transmit engine when a pending frame may go out. All timing advances on a bit-time tick enable, so the system clock rate does not matter. The gap is 96 bit times long and has two parts. The first part lasts 60 bit times, and carrier sense restarts it. The second part lasts 36 bit times, and carrier sense is ignored there, so a pending frame is launched when the gap ends even if that causes a collision.

After the block's own transmission, carrier sense is blinded for 40 bit times, measured from the last tick on which transmit was active. This stops the transceiver's SQE test burst from being taken as carrier. Carrier sense that arrives while the window is open does not reopen it. Between bit 41 and bit 60 after a transmission, carrier restarts the gap only when the post-transmit split is enabled. A configuration input turns that split off, and then carrier cannot restart a gap that follows a transmission.

Ticks are numbered from a reference tick. The reference tick is the last tick that saw carrier, or transmit active, or the restarting event. The tick right after reset also serves as a reference. Ticks 1 to 60 after the reference form the first part. Ticks 61 to 96 form the second part. A pending frame is granted on tick 97.

Top module: `ifg_deferral`

## Requirements
- R1: After synchronous active-high reset, `defer` is 1 and `tx_go` is 0. A frame pending from reset onward is granted on the 97th tick after reset.
- R2: State changes only on cycles where `bit_tick` is 1, and `tx_go` is never 1 in a cycle without `bit_tick`.
- R3: After a receive, the gap is timed from the last tick with `crs` = 1, and a pending frame is granted on the 97th tick after that tick.
- R4: Outside a post-transmit gap, `crs` = 1 on any of ticks 1 to 60 after the reference restarts the gap from that tick.
- R5: `crs` = 1 on ticks 61 to 97 has no effect, and the pending frame is still granted on tick 97.
- R6: `tx_go` is a single-cycle strobe. It is issued only with `tx_pending` = 1 and `defer` = 0, and `defer` is 1 in the cycle after it.
- R7: When the gap completes with nothing pending, `defer` drops to 0. A frame that becomes pending later is granted on the first tick that sees `tx_pending` = 1.
- R8: In the ready state with nothing pending, a tick with `crs` = 1 restarts the gap and `defer` returns to 1.
- R9: While `tx_active` is 1, the gap count is held at zero. Timing starts from the last tick on which `tx_active` was 1.
- R10: `crs` on ticks 1 to 40 after a transmission is ignored.
- R11: When `tx_split_off` = 0, `crs` on ticks 41 to 60 after a transmission restarts the gap.
- R12: When `tx_split_off` = 1, `crs` anywhere in a post-transmit gap does not restart it.
- R13: Carrier during the blinding window does not extend it. With `crs` on tick 20 and tick 41 after a transmission, tick 41 restarts the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle enable per bit time |
| crs | input | 1 | Receive carrier sense |
| tx_active | input | 1 | Local transmitter is sending |
| tx_pending | input | 1 | A frame waits to be sent |
| tx_split_off | input | 1 | 1 disables the two-part split after transmission |
| defer | output | 1 | 1 while the gap is not complete |
| tx_go | output | 1 | One-cycle grant to start the pending frame |

## Verification
The grant tick is tested with several carrier patterns, and each one separates a different timing rule:
- Quiet line after reset and after a receive. This checks where the 96-bit count starts.
- Carrier exactly on tick 60 or on ticks 61 to 97. This checks the boundary between the restartable part and the locked part.
- After a transmission, carrier inside the blind window, carrier at tick 50, and carrier at ticks 45 to 55 with the split disabled. These tell blinding apart from restarting and from the disable input.
- Carrier on tick 20 and then tick 41. A design that reopens the blind window on carrier would grant 41 ticks early.

A frame that becomes pending only after the gap has completed, with the tick held off for several cycles, shows whether the grant is immediate and tied to the tick.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  // first part of the gap: carrier still restarts timing
  function automatic logic in_restart_part(input int unsigned cnt, input int unsigned part1);
    return cnt < part1;
  endfunction

  // gap complete: count has reached the full interframe length
  function automatic logic gap_done(input int unsigned cnt, input int unsigned gap);
    return cnt == gap;
  endfunction

  // blinding active while fewer than blind bit times elapsed after transmit
  function automatic logic blind_open(input int unsigned cnt, input int unsigned blind);
    return cnt < blind;
  endfunction
endpackage

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter
  import ifg_pkg::*;
#(
  parameter int unsigned GAP_BITS   = 96,
  parameter int unsigned PART1_BITS = 60,
  localparam int unsigned CW = $clog2(GAP_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          hold,
  input  logic          restart,
  input  logic          grant,
  output logic [CW-1:0] gap_cnt,
  output logic          ready,
  output logic          part1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
    end else if (bit_tick) begin
      if (hold || restart || grant) gap_cnt <= '0;
      else if (!ready)              gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign ready = gap_done(32'(gap_cnt), GAP_BITS);
  assign part1 = in_restart_part(32'(gap_cnt), PART1_BITS);

  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (rst)
    bit_tick && hold |=> gap_cnt == '0);
  assert_no_tick_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(gap_cnt));
  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (rst)
    ready && !bit_tick |=> ready);
endmodule

// File: rtl/ifg_blind_window.sv
module ifg_blind_window
  import ifg_pkg::*;
#(
  parameter int unsigned BLIND_BITS = 40,
  localparam int unsigned BW = $clog2(BLIND_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic tx_event,
  output logic blinding
);
  logic [BW-1:0] blind_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      blind_cnt <= BW'(BLIND_BITS);
    end else if (bit_tick) begin
      if (tx_event)      blind_cnt <= '0;
      else if (blinding) blind_cnt <= blind_cnt + 1'b1;
    end
  end

  assign blinding = blind_open(32'(blind_cnt), BLIND_BITS);

  // carrier has no path into this counter: the window only advances
  assert_blind_no_restart_R13: assert property (@(posedge clk) disable iff (rst)
    bit_tick && !tx_event && blinding |=> blind_cnt == BW'($past(blind_cnt) + 1'b1));
  assert_blind_opens_R10: assert property (@(posedge clk) disable iff (rst)
    bit_tick && tx_event |=> blinding);
endmodule

// File: rtl/ifg_deferral.sv
module ifg_deferral
  import ifg_pkg::*;
#(
  parameter int unsigned GAP_BITS   = 96,
  parameter int unsigned PART1_BITS = 60,
  parameter int unsigned BLIND_BITS = 40,
  localparam int unsigned CW = $clog2(GAP_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic crs,
  input  logic tx_active,
  input  logic tx_pending,
  input  logic tx_split_off,
  output logic defer,
  output logic tx_go
);
  logic [CW-1:0] gap_cnt;
  logic ready, part1, blinding;
  logic after_tx;      // current gap follows our own transmission
  logic crs_seen;      // carrier after blinding
  logic split_locked;  // post-transmit split disabled for this gap
  logic restart;
  logic tx_event;

  assign tx_event     = tx_active || tx_go;
  assign crs_seen     = crs && !(after_tx && blinding);
  assign split_locked = after_tx && tx_split_off;
  assign restart      = !tx_active && crs_seen &&
                        (ready ? !tx_pending : (part1 && !split_locked));
  assign tx_go        = bit_tick && ready && tx_pending && !tx_active;
  assign defer        = !ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      after_tx <= 1'b0;
    end else if (bit_tick) begin
      if (tx_event)              after_tx <= 1'b1;
      else if (restart || ready) after_tx <= 1'b0;
    end
  end

  ifg_gap_counter #(.GAP_BITS(GAP_BITS), .PART1_BITS(PART1_BITS)) u_gap (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .hold(tx_active),
    .restart(restart), .grant(tx_go),
    .gap_cnt(gap_cnt), .ready(ready), .part1(part1)
  );

  ifg_blind_window #(.BLIND_BITS(BLIND_BITS)) u_blind (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_event(tx_event),
    .blinding(blinding)
  );

  assert_go_single_R6: assert property (@(posedge clk) disable iff (rst)
    tx_go |=> !tx_go && defer);
  assert_part2_counts_R5: assert property (@(posedge clk) disable iff (rst)
    bit_tick && !tx_active && !ready && !part1 |=> gap_cnt == CW'($past(gap_cnt) + 1'b1));
  assert_split_off_counts_R12: assert property (@(posedge clk) disable iff (rst)
    bit_tick && after_tx && tx_split_off && !tx_active && !ready
    |=> gap_cnt == CW'($past(gap_cnt) + 1'b1));
  assert_part1_restart_R4: assert property (@(posedge clk) disable iff (rst)
    bit_tick && !tx_active && crs && !after_tx && part1 |=> gap_cnt == '0 && defer);
endmodule

// File: tb/ifg_deferral_tb.sv
module ifg_deferral_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic bit_tick = 1'b0, crs = 1'b0, tx_active = 1'b0, tx_pending = 1'b0, tx_split_off = 1'b0;
  logic defer, tx_go;

  int n_chk = 0, n_bad = 0;
  int drv_tick = 0, mon_tick = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  ifg_deferral u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .crs(crs), .tx_active(tx_active),
    .tx_pending(tx_pending), .tx_split_off(tx_split_off), .defer(defer), .tx_go(tx_go)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one bit time: inputs and tick set at a falling edge, tick held one cycle
  task automatic tk(input bit c, input bit ta, input bit p);
    @(negedge clk);
    crs = c; tx_active = ta; tx_pending = p; bit_tick = 1'b1;
    drv_tick++;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic push_exp(input int t, input string tag);
    exp_q.push_back(t);
    tag_q.push_back(tag);
  endtask

  task automatic drained(input string tag);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic tx_burst(input int n);
    for (int i = 0; i < n; i++) tk(1'b1, 1'b1, 1'b0);
  endtask

  task automatic idle(input int n, input bit p);
    for (int i = 0; i < n; i++) tk(1'b0, 1'b0, p);
  endtask

  // pending gap with carrier on ticks a1..b1 and a2..b2 after the reference
  task automatic gap_run(input int a1, input int b1, input int a2, input int b2, input int n);
    for (int k = 1; k <= n; k++)
      tk((k >= a1 && k <= b1) || (k >= a2 && k <= b2), 1'b0, 1'b1);
  endtask

  task automatic chk_defer(input bit e, input string tag);
    #2 check(defer == e, tag, defer, e);
  endtask

  // monitor: scoreboard side, samples away from clock edges
  always @(negedge clk) begin
    #5;
    if (!rst) begin
      if (bit_tick) mon_tick++;
      if (tx_go) begin
        check(bit_tick == 1'b1, "R2 grant without tick", 0, 1);
        check(tx_pending == 1'b1, "R6 grant without pending", 0, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected grant", mon_tick, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(e == mon_tick, t, mon_tick, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    #2;
    check(defer == 1'b1, "R1 reset defer", defer, 1);
    check(tx_go == 1'b0, "R1 reset tx_go", tx_go, 0);
    @(negedge clk);
    rst = 1'b0;
    #2 check(defer == 1'b1, "R1 defer after reset", defer, 1);

    // R1: pending from reset waits a full gap
    push_exp(97, "R1 grant after reset");
    idle(97, 1'b1);
    chk_defer(1'b1, "R6 defer after grant");
    drained("R1 drained");

    // R9 R10: transmit, then loopback carrier inside blind window
    tx_burst(10); r = drv_tick;
    push_exp(r + 97, "R10 blind ignores carrier");
    gap_run(1, 40, 0, 0, 97);
    drained("R10 drained");

    // R11: carrier at tick 50 restarts
    tx_burst(5); r = drv_tick;
    push_exp(r + 50 + 97, "R11 post-tx restart");
    gap_run(50, 50, 0, 0, 147);
    drained("R11 drained");

    // R12: split disabled, carrier ignored
    tx_split_off = 1'b1;
    tx_burst(5); r = drv_tick;
    push_exp(r + 97, "R12 split off no restart");
    gap_run(45, 55, 0, 0, 97);
    drained("R12 drained");
    tx_split_off = 1'b0;

    // R13: carrier in window does not extend it
    tx_burst(5); r = drv_tick;
    push_exp(r + 41 + 97, "R13 window not extended");
    gap_run(20, 20, 41, 41, 138);
    drained("R13 drained");

    // R7 R8 R3: ready with nothing pending, then receive
    tx_burst(5);
    idle(100, 1'b0);
    chk_defer(1'b0, "R7 ready defer low");
    tk(1'b1, 1'b0, 1'b0);
    chk_defer(1'b1, "R8 carrier while ready");
    for (int i = 0; i < 19; i++) tk(1'b1, 1'b0, 1'b1);
    r = drv_tick;
    push_exp(r + 97, "R3 receive gap");
    gap_run(0, 0, 0, 0, 97);
    drained("R3 drained");

    // R7 R2: late pending, tick held off
    tx_burst(5);
    idle(100, 1'b0);
    @(negedge clk);
    tx_pending = 1'b1;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0 && defer == 1'b0, "R2 no grant without tick", defer, 0);
    push_exp(drv_tick + 1, "R7 immediate grant");
    tk(1'b0, 1'b0, 1'b1);
    drained("R7 drained");

    // R4: carrier on tick 60 of receive gap restarts
    tx_burst(5);
    idle(100, 1'b0);
    for (int i = 0; i < 5; i++) tk(1'b1, 1'b0, 1'b0);
    r = drv_tick;
    push_exp(r + 60 + 97, "R4 tick 60 restarts");
    gap_run(60, 60, 0, 0, 157);
    drained("R4 drained");

    // R5: carrier on ticks 61..97 ignored, collision allowed
    tx_burst(5);
    idle(100, 1'b0);
    for (int i = 0; i < 5; i++) tk(1'b1, 1'b0, 1'b0);
    r = drv_tick;
    push_exp(r + 97, "R5 second part locked");
    gap_run(61, 97, 0, 0, 97);
    drained("R5 drained");

    idle(3, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule